// File: doc/BRIEF.md
# Triggered Detector Random Bit Unit

This block turns single-photon-detector pulses into one fresh random bit per external trigger. Each detector line is asynchronous to the system clock. It passes through a short synchronizer and a rising-edge detector. The block has two identical paths. Each path holds a counter that is cleared by the trigger and then runs freely. Each path keeps the parity of its counter at the first photon edge it sees after the trigger. The two path bits are XORed to form the result.

A trigger input clears every piece of generation state: synchronizer flops, counters, captured path bits and any result that is not yet used. The next bit therefore depends only on detector activity after that trigger. The result is offered once on a valid/ready stream. The result is also copied to an auxiliary pin, which keeps that value until the next result is produced. The stream follows these rules. The valid signal rises only with a new result. While ready is low, valid stays high and the data does not change. The transfer takes place on the first clock edge where valid and ready are both high, and valid falls after that edge. Back-pressure never loses the bit. The only exception is a trigger, which drops the offered bit.

Top module: `trig_rbit_unit`

## Requirements
- R1: Each detector line passes through a two-flop synchronizer. Each path counter is cleared by the trigger edge (edge 0) and counts one per clock after it. Suppose a detector line is first sampled high at edge d after the trigger edge, with d of 1 or more. The bit of that path is then the XOR-reduction (odd parity) of d+1, taken over CNT_W=8 bits.
- R2: Each path uses only its first rising edge after a trigger. A level held high, or a later pulse on the same line, has no effect on the result.
- R3: The result on rbit_data_o is the XOR of the two path bits. rbit_valid_o first reads high after edge max(dA,dB)+3, where dA and dB are the edges defined in R1 for the two detector lines.
- R4: No result is offered until both paths have captured a bit since the last trigger. With one detector silent, rbit_valid_o stays low indefinitely.
- R5: A trigger clears the synchronizers, counters and captured bits, and it drops an offered result. rbit_valid_o is low on the cycle after a trigger. The next result and its timing follow R1 and R3, counted from the new trigger only.
- R6: While rbit_valid_o is high and rbit_ready_i is low, rbit_valid_o and rbit_data_o hold. After an edge where both are high, rbit_valid_o is low. At most one result is offered per trigger.
- R7: aux_o takes the new result in the same cycle that rbit_valid_o rises. It keeps that value through handshakes and triggers until the next result.
- R8: After reset, rbit_valid_o, rbit_data_o and aux_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Synchronous restart trigger, one cycle wide |
| det_i | input | 2 | Asynchronous detector pulses, one per path |
| rbit_valid_o | output | 1 | Stream valid for the random bit |
| rbit_data_o | output | 1 | Random bit |
| rbit_ready_i | input | 1 | Stream ready from the consumer |
| aux_o | output | 1 | Auxiliary pin holding the latest result |

## Verification
A table of detector arrival edges drives the main function. The table mixes equal arrivals, path A first, path B first and widely spaced arrivals. This separates a design that uses the wrong counter value or the wrong path from one that times the valid signal by the earlier detector instead of the later one. A split pulse on one line, with a second edge before the result, shows whether later edges are wrongly captured. A trigger issued after only one path has fired shows whether a stale path bit leaks into the next result, because the stale bit would change both the value and its arrival cycle. A run with one silent detector and checks of the aux pin across triggers cover the hold and no-result cases.

// File: rtl/trb_pkg.sv
package trb_pkg;
  typedef struct packed {
    logic done;
    logic bitv;
  } path_res_t;
endpackage

// File: rtl/trb_edge_sync.sv
module trb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else if (clr_i) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/trb_path.sv
module trb_path
  import trb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      det_i,
  output path_res_t res_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  path_res_t        res_q;

  trb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .async_i (det_i),
    .rise_o  (rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (clr_i) begin
      res_q <= '0;
    end else if (rise && !res_q.done) begin
      res_q.done <= 1'b1;
      res_q.bitv <= ^cnt_q;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/trig_rbit_unit.sv
module trig_rbit_unit
  import trb_pkg::*;
#(
  parameter int NUM_PATHS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_i,
  input  logic [NUM_PATHS-1:0] det_i,
  output logic                 rbit_valid_o,
  output logic                 rbit_data_o,
  input  logic                 rbit_ready_i,
  output logic                 aux_o
);
  logic [NUM_PATHS-1:0] done_v;
  logic [NUM_PATHS-1:0] bit_v;
  logic                 all_done;
  logic                 mixed;
  logic                 issued_q;
  logic                 valid_q;
  logic                 data_q;
  logic                 aux_q;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    path_res_t res;
    trb_path #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (trig_i),
      .det_i (det_i[g]),
      .res_o (res)
    );
    assign done_v[g] = res.done;
    assign bit_v[g]  = res.bitv;
  end

  assign all_done = &done_v;
  assign mixed    = ^bit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      data_q   <= 1'b0;
      aux_q    <= 1'b0;
      issued_q <= 1'b0;
    end else if (trig_i) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      if (valid_q && rbit_ready_i) valid_q <= 1'b0;
      if (all_done && !issued_q) begin
        valid_q  <= 1'b1;
        data_q   <= mixed;
        aux_q    <= mixed;
        issued_q <= 1'b1;
      end
    end
  end

  assign rbit_valid_o = valid_q;
  assign rbit_data_o  = data_q;
  assign aux_o        = aux_q;
endmodule

// File: rtl/trig_rbit_unit_chk.sv
module trig_rbit_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic rbit_valid_o,
  input logic rbit_data_o,
  input logic rbit_ready_i,
  input logic aux_o
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit_valid_o && !rbit_ready_i && !trig_i) |=> (rbit_valid_o && $stable(rbit_data_o)));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit_valid_o && rbit_ready_i) |=> !rbit_valid_o);

  p_trig_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> !rbit_valid_o);

  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbit_valid_o) |-> (!$past(trig_i, 1) && !$past(trig_i, 2)));

  p_aux_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbit_valid_o) |-> (aux_o == rbit_data_o));

  p_aux_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_o) |-> $rose(rbit_valid_o));
endmodule

bind trig_rbit_unit trig_rbit_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .rbit_valid_o (rbit_valid_o),
  .rbit_data_o  (rbit_data_o),
  .rbit_ready_i (rbit_ready_i),
  .aux_o        (aux_o)
);

// File: tb/trig_rbit_unit_tb.sv
module trig_rbit_unit_tb;
  localparam int CNT_W = 8;
  localparam int NVEC  = 7;
  localparam int VEC_A [NVEC] = '{1, 2, 7, 4, 10, 1, 6};
  localparam int VEC_B [NVEC] = '{1, 5, 3, 4, 1, 12, 9};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic [1:0] det = 2'b00;
  logic       ready = 1'b0;
  logic       valid, data, aux;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trig_rbit_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig),
    .det_i        (det),
    .rbit_valid_o (valid),
    .rbit_data_o  (data),
    .rbit_ready_i (ready),
    .aux_o        (aux)
  );

  function automatic logic par(input int v);
    logic [CNT_W-1:0] t;
    t = v[CNT_W-1:0];
    return ^t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_trig();
    @(negedge clk);
    trig = 1'b1;
    det  = 2'b00;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // After do_trig: step k is the negedge just before edge k; outputs seen there reflect edge k-1.
  task automatic run_steps(input int da, input int da_off, input int da_re, input int db,
                           input int nsteps, output int first_k, output logic first_bit);
    first_k = 0;
    first_bit = 1'b0;
    for (int k = 1; k <= nsteps; k++) begin
      det[0] = ((da != 0) && (k >= da) && ((da_off == 0) || (k < da_off))) ||
               ((da_re != 0) && (k >= da_re));
      det[1] = (db != 0) && (k >= db);
      if (valid && first_k == 0) begin
        first_k = k;
        first_bit = data;
      end
      @(negedge clk);
    end
  endtask

  task automatic handshake(input string req, input logic expb);
    check({req, " valid held while ready low"}, valid, 1);
    check({req, " data held while ready low"}, data, expb);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    check({req, " valid low after handshake"}, valid, 0);
    check({req, " aux keeps result"}, aux, expb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int   k;
    logic b;
    logic expb;
    logic aux_before;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid after reset", valid, 0);
    check("R8 data after reset", data, 0);
    check("R8 aux after reset", aux, 0);

    // R1 R3 main table
    for (int i = 0; i < NVEC; i++) begin
      int mx;
      mx = (VEC_A[i] > VEC_B[i]) ? VEC_A[i] : VEC_B[i];
      expb = par(VEC_A[i] + 1) ^ par(VEC_B[i] + 1);
      do_trig();
      run_steps(VEC_A[i], 0, 0, VEC_B[i], mx + 8, k, b);
      check($sformatf("R3 vec%0d valid step", i), k, mx + 4);
      check($sformatf("R1 vec%0d bit", i), b, expb);
      check($sformatf("R7 vec%0d aux", i), aux, expb);
      handshake("R6", expb);
    end

    // R5 R7: trigger keeps aux, clears valid
    aux_before = aux;
    do_trig();
    check("R5 valid low after trigger", valid, 0);
    check("R7 aux held across trigger", aux, aux_before);

    // R4: one silent detector
    run_steps(2, 0, 0, 0, 30, k, b);
    check("R4 no result with one path silent", k, 0);
    check("R4 aux unchanged", aux, aux_before);

    // R5: stale path A bit (parity 3 = 0) must be discarded
    do_trig();
    run_steps(6, 0, 0, 1, 16, k, b);
    check("R5 fresh timing after discard", k, 10);
    check("R5 fresh bit after discard", b, par(7) ^ par(2));
    handshake("R5", par(7) ^ par(2));

    // R2: path A split pulse, first edge at 3, second at 5; B at 7
    do_trig();
    run_steps(3, 4, 5, 7, 16, k, b);
    check("R2 timing with second pulse", k, 11);
    check("R2 second edge ignored", b, par(4) ^ par(8));
    handshake("R2", par(4) ^ par(8));

    // R6: at most one result per trigger, level held high
    run_steps(1, 0, 0, 1, 10, k, b);
    check("R6 no second result without trigger", k, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule